// File: doc/BRIEF.md
# Control-Flow Signature Watchdog

This block watches the instruction-fetch traffic between a processor and its memory system and checks that the program follows its intended control flow. The code is split into nodes: runs of straight-line instructions that each end with a branch. While a node is being fetched, the block folds every fetched instruction into a 16-bit multiple-input signature register. When the processor's branch logic marks the closing branch, the block compares the accumulated signature with a reference value that was placed into the node's own code stream.

Each node also carries one reference word. That word holds the node's identity, the identities of the two nodes it may hand control to (one for a taken branch, one for a fall-through), and the expected signature. When the next node's reference word arrives, its identity is checked against the successor that the previous branch outcome selected. Any violation raises a sticky error flag with a two-bit cause code, which software clears with a one-cycle pulse.

The block only observes. It never stalls or alters the fetch stream, so it can sit on the bus beside the processor.

Top module: `cfc_watchdog`

## Requirements
- R1: After reset `err_flag` is 0 and `err_code` is 0, and `err_code` stays 0 whenever `err_flag` is 0.
- R2: The signature starts at 16'hFFFF at the beginning of each node. For every accepted non-reference word w, including the closing branch word, it updates as s = {s[14:0],1'b0} ^ (s[15] ? 16'h1021 : 16'h0000) ^ (w[31:16] ^ w[15:0]). A node whose final signature equals its reference raises no error.
- R3: At a closing branch whose final signature differs from the node's reference signature, the block records error code 1.
- R4: At a closing branch in a node that contained no reference word, the block records error code 2.
- R5: Reference word fields are as follows: bits [27:24] hold the node ID, bits [23:20] the successor taken on a taken branch, and bits [19:16] the successor on a fall-through. When a reference word arrives, its ID is compared with the successor that the previous node's branch outcome (`branch_taken`) selected, and a difference records error code 3. This check is skipped for the first node after reset and for a node that follows a node without a reference word.
- R6: A word whose bits [31:28] are 4'b1111 is a reference word. Bits [15:0] carry the expected signature, and the word is not folded into the signature, wherever it sits in the node.
- R7: Once set, `err_flag` and `err_code` keep the first recorded error through later errors and later good nodes until `err_clear` is asserted.
- R8: `err_clear` returns the flag and the code to 0 on the next cycle. If an error is detected in the same cycle as the clear, that new error is recorded instead.
- R9: While `fetch_valid` is 0, `fetch_word`, `branch_end` and `branch_taken` have no effect on the signature, on the node state or on the error outputs.
- R10: Error outputs are registered: an error detected on a fetch cycle appears on the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_valid | input | 1 | Qualifies the fetch word and branch inputs this cycle |
| fetch_word | input | 32 | Instruction or reference word fetched by the processor |
| branch_end | input | 1 | The fetched word is the branch that closes the current node |
| branch_taken | input | 1 | Outcome of that closing branch (1 = taken) |
| err_clear | input | 1 | Software pulse that clears the sticky error |
| err_flag | output | 1 | Sticky control-flow error indication |
| err_code | output | 2 | Cause: 1 signature mismatch, 2 missing reference, 3 illegal arc |

## Verification
The assertions assume that a reference word never arrives on a closing-branch cycle and that each node holds at most one reference word. The stimulus builds every node from ordinary words whose top nibble is never 4'b1111, with the reference word placed before the branch. Idle cycles deliberately drive reference-like words and a raised `branch_end` with `fetch_valid` low, so that the masking checks have something to ignore. Expected signatures are computed in the bench from the update rule in R2, and a deliberately corrupted reference bit produces the mismatch cases.

// File: rtl/cfc_pkg.sv
package cfc_pkg;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_SIG   = 2'd1,
        ERR_NOREF = 2'd2,
        ERR_ARC   = 2'd3
    } cfc_err_e;

endpackage

// File: rtl/cfc_ref_decode.sv
module cfc_ref_decode #(
    parameter int WORD_W = 32,
    parameter int SIG_W  = 16,
    parameter int ID_W   = 4,
    parameter int MARK_W = 4,
    parameter logic [MARK_W-1:0] MARK = '1
) (
    input  logic [WORD_W-1:0] word_i,
    output logic              is_ref_o,
    output logic [ID_W-1:0]   id_o,
    output logic [ID_W-1:0]   succ_t_o,
    output logic [ID_W-1:0]   succ_f_o,
    output logic [SIG_W-1:0]  sig_o
);
    localparam int ID_LSB = WORD_W - MARK_W - ID_W;
    localparam int ST_LSB = ID_LSB - ID_W;
    localparam int SF_LSB = ST_LSB - ID_W;

    always_comb begin
        is_ref_o = (word_i[WORD_W-1 -: MARK_W] == MARK);
        id_o     = word_i[ID_LSB +: ID_W];
        succ_t_o = word_i[ST_LSB +: ID_W];
        succ_f_o = word_i[SF_LSB +: ID_W];
        sig_o    = word_i[SIG_W-1:0];
    end
endmodule

// File: rtl/cfc_misr.sv
module cfc_misr #(
    parameter int WORD_W = 32,
    parameter int SIG_W  = 16,
    parameter logic [SIG_W-1:0] POLY = 16'h1021
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              restart_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [SIG_W-1:0]  sig_fin_o,
    output logic [SIG_W-1:0]  sig_q_o
);
    localparam int CHUNKS = WORD_W / SIG_W;

    typedef struct packed {
        logic [SIG_W-1:0] sig;
    } misr_st_t;

    misr_st_t st_d, st_q;

    function automatic logic [SIG_W-1:0] fold(input logic [WORD_W-1:0] w);
        logic [SIG_W-1:0] f;
        f = '0;
        for (int k = 0; k < CHUNKS; k++) begin
            f ^= w[k*SIG_W +: SIG_W];
        end
        return f;
    endfunction

    function automatic logic [SIG_W-1:0] advance(input logic [SIG_W-1:0] s,
                                                 input logic [SIG_W-1:0] f);
        return {s[SIG_W-2:0], 1'b0} ^ (s[SIG_W-1] ? POLY : '0) ^ f;
    endfunction

    always_comb begin
        st_d      = st_q;
        sig_fin_o = step_i ? advance(st_q.sig, fold(word_i)) : st_q.sig;
        st_d.sig  = sig_fin_o;
        if (restart_i) begin
            st_d.sig = '1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sig: '1};
        end else begin
            st_q <= st_d;
        end
    end

    assign sig_q_o = st_q.sig;

    assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (sig_q_o == '1));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !restart_i) |=> $stable(sig_q_o));
endmodule

// File: rtl/cfc_node_track.sv
module cfc_node_track #(
    parameter int SIG_W = 16,
    parameter int ID_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_i,
    input  logic             branch_i,
    input  logic             taken_i,
    input  logic [ID_W-1:0]  ref_id_i,
    input  logic [ID_W-1:0]  ref_st_i,
    input  logic [ID_W-1:0]  ref_sf_i,
    input  logic [SIG_W-1:0] ref_sig_i,
    input  logic [SIG_W-1:0] sig_fin_i,
    output logic             ev_sig_o,
    output logic             ev_noref_o,
    output logic             ev_arc_o
);
    typedef struct packed {
        logic             ref_seen;
        logic [SIG_W-1:0] ref_sig;
        logic [ID_W-1:0]  pend_t;
        logic [ID_W-1:0]  pend_f;
        logic             ctx_valid;
        logic [ID_W-1:0]  exp_id;
    } trk_st_t;

    trk_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        ev_sig_o   = 1'b0;
        ev_noref_o = 1'b0;
        ev_arc_o   = 1'b0;
        if (ref_i) begin
            st_d.ref_seen = 1'b1;
            st_d.ref_sig  = ref_sig_i;
            st_d.pend_t   = ref_st_i;
            st_d.pend_f   = ref_sf_i;
            if (st_q.ctx_valid && (ref_id_i != st_q.exp_id)) begin
                ev_arc_o = 1'b1;
            end
        end
        if (branch_i) begin
            if (!st_q.ref_seen) begin
                ev_noref_o = 1'b1;
            end else if (sig_fin_i != st_q.ref_sig) begin
                ev_sig_o = 1'b1;
            end
            st_d.ctx_valid = st_q.ref_seen;
            st_d.exp_id    = taken_i ? st_q.pend_t : st_q.pend_f;
            st_d.ref_seen  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // A node's ref word must be consumed by its closing branch: the next node starts clean.
    assert_node_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (branch_i && !ref_i) |=> !st_q.ref_seen);
endmodule

// File: rtl/cfc_watchdog.sv
module cfc_watchdog #(
    parameter int WORD_W = 32,
    parameter int SIG_W  = 16,
    parameter int ID_W   = 4,
    parameter int MARK_W = 4,
    parameter logic [SIG_W-1:0] POLY = 16'h1021
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [WORD_W-1:0] fetch_word,
    input  logic              branch_end,
    input  logic              branch_taken,
    input  logic              err_clear,
    output logic              err_flag,
    output logic [1:0]        err_code
);
    import cfc_pkg::*;

    localparam logic [MARK_W-1:0] MARK = '1;

    typedef struct packed {
        logic     flag;
        cfc_err_e code;
    } err_st_t;

    logic             is_ref;
    logic [ID_W-1:0]  ref_id, ref_st, ref_sf;
    logic [SIG_W-1:0] ref_sig, sig_fin, sig_run;
    logic             acc_ref, acc_ins, acc_br;
    logic             ev_sig, ev_noref, ev_arc, ev_any;
    cfc_err_e         ev_code;
    err_st_t          err_d, err_q;

    cfc_ref_decode #(
        .WORD_W(WORD_W), .SIG_W(SIG_W), .ID_W(ID_W), .MARK_W(MARK_W), .MARK(MARK)
    ) u_dec (
        .word_i   (fetch_word),
        .is_ref_o (is_ref),
        .id_o     (ref_id),
        .succ_t_o (ref_st),
        .succ_f_o (ref_sf),
        .sig_o    (ref_sig)
    );

    assign acc_ref = fetch_valid && is_ref;
    assign acc_ins = fetch_valid && !is_ref;
    assign acc_br  = fetch_valid && branch_end;

    cfc_misr #(.WORD_W(WORD_W), .SIG_W(SIG_W), .POLY(POLY)) u_misr (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (acc_ins),
        .restart_i (acc_br),
        .word_i    (fetch_word),
        .sig_fin_o (sig_fin),
        .sig_q_o   (sig_run)
    );

    cfc_node_track #(.SIG_W(SIG_W), .ID_W(ID_W)) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_i      (acc_ref),
        .branch_i   (acc_br),
        .taken_i    (branch_taken),
        .ref_id_i   (ref_id),
        .ref_st_i   (ref_st),
        .ref_sf_i   (ref_sf),
        .ref_sig_i  (ref_sig),
        .sig_fin_i  (sig_fin),
        .ev_sig_o   (ev_sig),
        .ev_noref_o (ev_noref),
        .ev_arc_o   (ev_arc)
    );

    always_comb begin
        ev_any  = ev_sig || ev_noref || ev_arc;
        ev_code = ev_arc   ? ERR_ARC   :
                  ev_noref ? ERR_NOREF :
                  ev_sig   ? ERR_SIG   : ERR_NONE;
        err_d = err_q;
        if (err_clear) begin
            err_d.flag = ev_any;
            err_d.code = ev_code;
        end else if (ev_any && !err_q.flag) begin
            err_d.flag = 1'b1;
            err_d.code = ev_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= '{flag: 1'b0, code: ERR_NONE};
        end else begin
            err_q <= err_d;
        end
    end

    assign err_flag = err_q.flag;
    assign err_code = err_q.code;

    assert_code_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !err_flag |-> (err_code == 2'd0));

    assert_ref_excluded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ref && !branch_end) |=> $stable(sig_run));

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clear) |=> (err_flag && $stable(err_code)));

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clear && !ev_any) |=> !err_flag);

    assert_clear_race_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clear && ev_any) |=> err_flag);
endmodule

// File: tb/cfc_watchdog_tb_top.sv
module cfc_watchdog_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_word = '0;
    logic        branch_end = 1'b0;
    logic        branch_taken = 1'b0;
    logic        err_clear = 1'b0;
    logic        err_flag;
    logic [1:0]  err_code;

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    cfc_watchdog dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_valid  (fetch_valid),
        .fetch_word   (fetch_word),
        .branch_end   (branch_end),
        .branch_taken (branch_taken),
        .err_clear    (err_clear),
        .err_flag     (err_flag),
        .err_code     (err_code)
    );

    typedef struct packed {
        logic [3:0] id;
        logic [3:0] st;
        logic [3:0] sf;
        logic       taken;
        logic [2:0] nbody;
        logic       has_ref;
        logic [2:0] refpos;
        logic       bad;
        logic       gap;
        logic [1:0] exp;
    } vec_t;

    // id, st, sf, taken, nbody, has_ref, refpos, bad, gap, exp
    localparam vec_t VEC [8] = '{
        '{4'd0, 4'd1, 4'd2, 1'b1, 3'd3, 1'b1, 3'd0, 1'b0, 1'b0, 2'd0}, // R2 first node
        '{4'd1, 4'd3, 4'd2, 1'b0, 3'd2, 1'b1, 3'd1, 1'b0, 1'b1, 2'd0}, // R2 R6 R9 ref mid, gaps
        '{4'd2, 4'd0, 4'd5, 1'b1, 3'd4, 1'b1, 3'd0, 1'b1, 1'b0, 2'd1}, // R3
        '{4'd0, 4'd1, 4'd1, 1'b0, 3'd1, 1'b1, 3'd0, 1'b0, 1'b0, 2'd0}, // R2 one-word node
        '{4'd7, 4'd4, 4'd4, 1'b1, 3'd2, 1'b1, 3'd0, 1'b0, 1'b0, 2'd3}, // R5 bad arc
        '{4'd4, 4'd0, 4'd0, 1'b0, 3'd2, 1'b0, 3'd0, 1'b0, 1'b1, 2'd2}, // R4
        '{4'd9, 4'd8, 4'd8, 1'b0, 3'd3, 1'b1, 3'd2, 1'b0, 1'b0, 2'd0}, // R5 no context
        '{4'd6, 4'd0, 4'd0, 1'b1, 3'd2, 1'b1, 3'd0, 1'b1, 1'b0, 2'd3}  // R5 R7 arc first
    };

    function automatic logic [15:0] sig_step(input logic [15:0] s, input logic [31:0] w);
        return {s[14:0], 1'b0} ^ (s[15] ? 16'h1021 : 16'h0000) ^ (w[31:16] ^ w[15:0]);
    endfunction

    function automatic logic [31:0] body_word(input int seed, input int i);
        logic [15:0] lo;
        lo = 16'h3A5C ^ 16'(seed * 16'h0111) ^ 16'(i * 16'h0F13);
        return {4'h1, 4'(seed), 8'(i), lo};
    endfunction

    task automatic drive(input logic v, input logic [31:0] w, input logic b,
                         input logic t, input logic c);
        @(negedge clk);
        fetch_valid  = v;
        fetch_word   = w;
        branch_end   = b;
        branch_taken = t;
        err_clear    = c;
    endtask

    task automatic idle_gap();
        drive(1'b0, 32'hF5A5_0000, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic check(input logic ef, input logic [1:0] ec, input string req);
        n_checks++;
        if (err_flag !== ef || err_code !== ec) begin
            n_fail++;
            $display("FAIL %s: flag/code actual %b/%0d expected %b/%0d",
                     req, err_flag, err_code, ef, ec);
        end
    endtask

    task automatic run_node(input vec_t v, input int seed, input logic clr_br);
        logic [15:0] s;
        logic [31:0] rw;
        s = 16'hFFFF;
        for (int i = 0; i < int'(v.nbody); i++) s = sig_step(s, body_word(seed, i));
        rw = {4'hF, v.id, v.st, v.sf, (v.bad ? (s ^ 16'h0001) : s)};
        for (int i = 0; i < int'(v.nbody); i++) begin
            if (v.has_ref && i == int'(v.refpos)) begin
                drive(1'b1, rw, 1'b0, 1'b0, 1'b0);
                if (v.gap) idle_gap();
            end
            if (i == int'(v.nbody) - 1)
                drive(1'b1, body_word(seed, i), 1'b1, v.taken, clr_br);
            else
                drive(1'b1, body_word(seed, i), 1'b0, 1'b0, 1'b0);
            if (v.gap && i != int'(v.nbody) - 1) idle_gap();
        end
        drive(1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(1'b0, 2'd0, "R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(1'b0, 2'd0, "R1 after release");

        foreach (VEC[k]) begin
            drive(1'b0, 32'h0, 1'b0, 1'b0, 1'b1);
            run_node(VEC[k], k + 3, 1'b0);
            check(VEC[k].exp != 2'd0, VEC[k].exp, $sformatf("R10 R2-R6 vector %0d", k));
        end

        // R7: a later signature mismatch must not replace the recorded arc error
        run_node('{4'd0, 4'd1, 4'd1, 1'b1, 3'd3, 1'b1, 3'd1, 1'b1, 1'b0, 2'd0}, 20, 1'b0);
        check(1'b1, 2'd3, "R7 sticky over new error");
        // R7: a good node leaves it set too
        run_node('{4'd1, 4'd1, 4'd1, 1'b1, 3'd2, 1'b1, 3'd0, 1'b0, 1'b0, 2'd0}, 21, 1'b0);
        check(1'b1, 2'd3, "R7 sticky over good node");

        // R8: clear on the same cycle as a missing-reference branch records code 2
        run_node('{4'd5, 4'd0, 4'd0, 1'b0, 3'd2, 1'b0, 3'd0, 1'b0, 1'b0, 2'd2}, 22, 1'b1);
        check(1'b1, 2'd2, "R8 error wins over clear");

        // R8: a plain clear empties it
        drive(1'b0, 32'h0, 1'b0, 1'b0, 1'b1);
        drive(1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
        check(1'b0, 2'd0, "R8 clear");

        // R9: masked branch strobes and reference-like words do nothing
        for (int i = 0; i < 4; i++) idle_gap();
        drive(1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
        check(1'b0, 2'd0, "R9 masked branch");

        // R9: a good node with masked noise between words keeps a clean signature
        run_node('{4'd3, 4'd2, 4'd2, 1'b0, 3'd4, 1'b1, 3'd3, 1'b0, 1'b1, 2'd0}, 23, 1'b0);
        check(1'b0, 2'd0, "R9 R6 noise ignored");

        // R5: successor chosen by fall-through (2), arriving id 2 is legal
        run_node('{4'd2, 4'd4, 4'd4, 1'b1, 3'd2, 1'b1, 3'd0, 1'b0, 1'b0, 2'd0}, 24, 1'b0);
        check(1'b0, 2'd0, "R5 legal arc");

        // R1: reset mid-error returns to idle
        run_node('{4'd1, 4'd0, 4'd0, 1'b0, 3'd2, 1'b1, 3'd0, 1'b0, 1'b0, 2'd3}, 25, 1'b0);
        check(1'b1, 2'd3, "R5 taken successor mismatch");
        rst_n = 1'b0;
        @(negedge clk);
        check(1'b0, 2'd0, "R1 reset clears error");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule